// File: doc/BRIEF.md
# Programmable Auto Shift/Rotate Unit

This block is a small multi-cycle shifter that sits behind a simple register-select write port and a separate read port. Software first programs an operating mode and a step count, then writes the operand. That write alone launches the sequence. The unit then moves the operand by one bit per clock, either shifting or rotating, to the left or to the right, until the programmed number of steps is complete. It then raises a done flag, which software finds in the status register.

The control is a three-state machine:
- `ST_IDLE` is the state after reset.
- `ST_BUSY` is the state in which steps are applied.
- `ST_DONE` holds the finished result.

Its transitions are these:
- **launch**: an operand write moves `ST_IDLE` or `ST_DONE` to `ST_BUSY` when the count is non-zero.
- **instant finish**: an operand write with a zero count moves `ST_IDLE` or `ST_DONE` to `ST_DONE`.
- **last step**: in `ST_BUSY`, when one step remains, the machine moves to `ST_DONE`.
- **restart**: an operand write in `ST_BUSY` reloads the operand and count and moves to `ST_BUSY` or `ST_DONE` by the same count rule.

While busy, writes to the mode and count registers are dropped, so the active sequence always runs on stable settings.

Top module: `autoshift_unit`

## Requirements
- R1: After reset the mode, count and result registers all read 0, and status reads 0, with neither done nor busy set.
- R2: Writes with select 0 store the mode and writes with select 1 store the count. In the mode, bit 0 selects the operation (0 = shift, 1 = rotate) and bit 1 selects the direction (0 = left, 1 = right). Reading select 0 returns the mode in bits 1:0 with all other bits 0. Reading select 1 returns the count.
- R3: A write with select 2 loads the operand and starts the sequence without any other command. With a non-zero count, busy (status bit 1) reads 1 on the cycle after that write.
- R4: Exactly one single-bit step is applied per clock while busy. If the write is captured at edge E0, done is first set and busy cleared after edge E(N), where N is the count. Counts above the data width are allowed.
- R5: In shift mode the bit vacated by each step is filled with 0. Left moves bit i to bit i+1, and right moves bit i+1 to bit i.
- R6: In rotate mode the bit leaving one end of the word re-enters at the other end in the same step.
- R7: With a count of 0, done is set on the cycle after the operand write and the result equals the operand.
- R8: A new operand write clears done. An operand write while busy abandons the running sequence and restarts with the new operand and the current count.
- R9: Writes to the mode or count while busy have no effect; the registers keep their values.
- R10: Reading select 2 returns the result, including intermediate values while busy. Reading select 3 returns status with bit 0 = done, bit 1 = busy and all other bits 0. Done and busy are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_sel | input | 2 | Write register select: 0 mode, 1 count, 2 operand |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 2 | Read register select: 0 mode, 1 count, 2 result, 3 status |
| rd_data | output | DATA_W | Read data, combinational from rd_sel and register state |

## Verification
Every result is due at a fixed edge counted from the edge that captures the operand write, called E0. Busy shows after E0 when the count is non-zero, the k-th intermediate result shows after E(k), and done shows after E(N), which is E0 itself for a count of zero. A configuration write is visible after its own capture edge. The bench advances its reference model at each rising edge and reads all four registers half a period later, so every due value is sampled in the first cycle it exists and in every cycle after it. Inputs change a further quarter period later, away from both the sampling point and the capture edge.

// File: rtl/autoshift_pkg.sv
package autoshift_pkg;

    // Register select codes shared by the write and read ports.
    localparam logic [1:0] SEL_MODE   = 2'd0;
    localparam logic [1:0] SEL_COUNT  = 2'd1;
    localparam logic [1:0] SEL_DATA   = 2'd2;
    localparam logic [1:0] SEL_STATUS = 2'd3;

    // Mode field layout: bit 0 operation, bit 1 direction.
    typedef struct packed {
        logic right;   // 1 = toward bit 0
        logic rot;     // 1 = wrap outgoing bit
    } mode_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } state_t;

endpackage

// File: rtl/autoshift_cfg.sv
module autoshift_cfg
    import autoshift_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output mode_t             mode,
    output logic [CNT_W-1:0]  count
);

    logic cfg_open;
    assign cfg_open = wr_en && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= '0;
        end else if (cfg_open && wr_sel == SEL_MODE) begin
            mode <= mode_t'(wr_data[1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (cfg_open && wr_sel == SEL_COUNT) begin
            count <= wr_data[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/autoshift_ctrl.sv
module autoshift_ctrl
    import autoshift_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    output logic             load,
    output logic             step_en,
    output logic             busy,
    output logic             done
);

    state_t           state_q;
    state_t           state_d;
    logic [CNT_W-1:0] left_q;
    logic             zero_cnt;
    logic             last_step;

    assign zero_cnt  = (count == '0);
    assign last_step = (left_q == CNT_W'(1));

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) state_d = zero_cnt ? ST_DONE : ST_BUSY;
            end
            ST_BUSY: begin
                if (start)          state_d = zero_cnt ? ST_DONE : ST_BUSY;
                else if (last_step) state_d = ST_DONE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        load    = start;
        busy    = 1'b0;
        done    = 1'b0;
        step_en = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_BUSY: begin
                busy    = 1'b1;
                step_en = !start;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    // Steps remaining
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       left_q <= '0;
        else if (start)   left_q <= count;
        else if (step_en) left_q <= left_q - CNT_W'(1);
    end

endmodule

// File: rtl/autoshift_datapath.sv
module autoshift_datapath
    import autoshift_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step_en,
    input  mode_t             mode,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] stepped;
    logic              wrap_lo;   // enters bit 0 on a left step
    logic              wrap_hi;   // enters the top bit on a right step

    assign wrap_lo = mode.rot & result[MSB];
    assign wrap_hi = mode.rot & result[0];

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic from_lo;
        logic from_hi;
        if (i == 0) begin : g_lo_edge
            assign from_lo = wrap_lo;
        end else begin : g_lo_mid
            assign from_lo = result[i-1];
        end
        if (i == MSB) begin : g_hi_edge
            assign from_hi = wrap_hi;
        end else begin : g_hi_mid
            assign from_hi = result[i+1];
        end
        assign stepped[i] = mode.right ? from_hi : from_lo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       result <= '0;
        else if (load)    result <= operand;
        else if (step_en) result <= stepped;
    end

endmodule

// File: rtl/autoshift_unit.sv
module autoshift_unit
    import autoshift_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data
);

    localparam int CNT_W = DATA_W;

    mode_t             cfg_mode;
    logic [CNT_W-1:0]  cfg_count;
    logic [DATA_W-1:0] res_w;
    logic              busy_w;
    logic              done_w;
    logic              load_w;
    logic              step_w;
    logic              start_w;

    assign start_w = wr_en && (wr_sel == SEL_DATA);

    autoshift_cfg #(.DATA_W(DATA_W), .CNT_W(CNT_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .busy(busy_w), .mode(cfg_mode), .count(cfg_count)
    );

    autoshift_ctrl #(.CNT_W(CNT_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start_w), .count(cfg_count),
        .load(load_w), .step_en(step_w), .busy(busy_w), .done(done_w)
    );

    autoshift_datapath #(.DATA_W(DATA_W)) dp_i (
        .clk(clk), .rst_n(rst_n), .load(load_w), .step_en(step_w),
        .mode(cfg_mode), .operand(wr_data), .result(res_w)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            SEL_MODE:   rd_data[1:0] = cfg_mode;
            SEL_COUNT:  rd_data      = cfg_count;
            SEL_DATA:   rd_data      = res_w;
            SEL_STATUS: rd_data[1:0] = {busy_w, done_w};
            default:    rd_data      = '0;
        endcase
    end

endmodule

// File: rtl/autoshift_chk.sv
module autoshift_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic [1:0]        cfg_mode,
    input logic [DATA_W-1:0] cfg_count,
    input logic [DATA_W-1:0] res_w,
    input logic              busy_w,
    input logic              done_w
);

    logic opw;
    assign opw = wr_en && (wr_sel == 2'd2);

    p_status_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_w && done_w));

    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && wr_en && wr_sel != 2'd2) |=> ($stable(cfg_mode) && $stable(cfg_count)));

    p_zero_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (opw && cfg_count == '0) |=> (done_w && res_w == $past(wr_data)));

    p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (opw && cfg_count != '0) |=> (busy_w && !done_w));

    p_shift_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && !opw && !cfg_mode[0]) |=> ($countones(res_w) <= $countones($past(res_w))));

    p_rotate_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && !opw && cfg_mode[0]) |=> ($countones(res_w) == $countones($past(res_w))));

    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_w && !opw) |=> done_w);

endmodule

bind autoshift_unit autoshift_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cfg_mode(cfg_mode), .cfg_count(cfg_count), .res_w(res_w),
    .busy_w(busy_w), .done_w(done_w)
);

// File: tb/autoshift_unit_tb_top.sv
`timescale 1ns/1ps
module autoshift_unit_tb_top;

    localparam int W    = 8;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = '0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_sel = '0;
    logic [W-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R1";

    // reference model state
    int m_mode = 0, m_cnt = 0, m_res = 0, m_rem = 0;
    bit m_busy = 0, m_done = 0;

    always #2 clk = ~clk;

    autoshift_unit #(.DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    function automatic int one_step(int v, int md);
        int r;
        if ((md & 2) == 0) begin
            r = (v << 1) & MASK;
            if ((md & 1) != 0) r = r | ((v >> (W - 1)) & 1);
        end else begin
            r = v >> 1;
            if ((md & 1) != 0) r = r | ((v & 1) << (W - 1));
        end
        return r;
    endfunction

    task automatic chk(string t, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", t, act, exp, cycles);
        end
    endtask

    // Model advance on each rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_res = 0; m_rem = 0; m_busy = 0; m_done = 0;
        end else if (wr_en && wr_sel == 2'd2) begin
            m_res = int'(wr_data);
            m_rem = m_cnt;
            m_busy = (m_cnt != 0);
            m_done = (m_cnt == 0);
        end else begin
            if (wr_en && !m_busy && wr_sel == 2'd0) m_mode = int'(wr_data) & 3;
            if (wr_en && !m_busy && wr_sel == 2'd1) m_cnt  = int'(wr_data);
            if (m_busy) begin
                m_res = one_step(m_res, m_mode);
                m_rem--;
                if (m_rem == 0) begin
                    m_busy = 0;
                    m_done = 1;
                end
            end
        end
    end

    // Compare all four read registers mid-cycle
    always @(negedge clk) begin
        rd_sel = 2'd0; #0.2; chk({tag, " R2 mode"}, int'(rd_data), m_mode);
        rd_sel = 2'd1; #0.2; chk({tag, " R2 count"}, int'(rd_data), m_cnt);
        rd_sel = 2'd2; #0.2; chk({tag, " R10 result"}, int'(rd_data), m_res);
        rd_sel = 2'd3; #0.2; chk({tag, " R10 status"}, int'(rd_data), (int'(m_busy) << 1) | int'(m_done));
    end

    task automatic wr(input logic [1:0] s, input int d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_sel = s; wr_data = W'(d);
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run(input string t, input int md, input int cnt, input int op);
        tag = t;
        wr(2'd0, md);
        wr(2'd1, cnt);
        wr(2'd2, op);
        idle(cnt + 3);
    endtask

    initial begin : watchdog
        #100000;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        #1 rst_n = 1'b1;
        idle(2);                               // R1 reset values compared
        tag = "R2";
        wr(2'd0, 8'hFF);                       // only bits 1:0 kept
        wr(2'd1, 8'h05);
        idle(2);
        run("R3", 0, 1, 8'h01);
        run("R5", 0, 3, 8'hB5);                // shift left
        run("R5", 2, 2, 8'h81);                // shift right
        run("R6", 1, 3, 8'h96);                // rotate left
        run("R4", 3, 11, 8'h5A);               // rotate right, count beyond width
        run("R4", 0, 9, 8'hFF);                // shift clears all bits
        run("R7", 2, 0, 8'h3C);                // zero count
        tag = "R8";
        wr(2'd1, 6);
        wr(2'd2, 8'h0F);
        idle(1);
        wr(2'd2, 8'h11);                       // restart while busy
        idle(9);
        wr(2'd2, 8'h22);                       // clears done
        idle(9);
        tag = "R9";
        wr(2'd1, 5);
        wr(2'd2, 8'hC3);
        wr(2'd0, 8'h03);                       // dropped while busy
        wr(2'd1, 8'h02);                       // dropped while busy
        idle(6);
        #0.5;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule